// File: doc/BRIEF.md
# Virtual-Mode Software Interrupt Redirector

This block decides, for a software interrupt raised while the processor runs in virtual-8086 mode, whether the interrupt goes through the real-mode vector table at physical address zero. When that path is taken, the block also carries out the delivery. On a start pulse it captures the vector number, the task-state segment base and limit, the mode-extension enable, and the current 16-bit flags image with the virtual interrupt flag, IP and CS. It then works through a short sequence of memory reads and stack pushes. The memory read port and the stack write port each finish one transfer per request/acknowledge handshake.

With the extensions enabled, the block reads the 16-bit I/O base word from the task-state segment. From that word it computes the offset of one byte of the redirection bitmap and checks the offset against the segment limit. It then fetches that byte and tests the bit selected by the vector. When the bit is clear, the block reads the vector-table entry. It pushes a flags image, the old CS and the old IP. It reports the new CS:IP and the flag bits that the core must clear. In every other case it reports either a fault or "not redirected", so the core can fall back to its protected-mode path.

Top module: `vint_redirect`

## Requirements
- R1: If `ext_en` is low at start, the block issues no read and no push. It reports fault (code 2'b11) when IOPL (`flags_in[13:12]`) is below 3, and not redirected (code 2'b10) otherwise.
- R2: If `ext_en` is high and `tr_limit` is below 103, the block reports fault without any read. A limit of exactly 103 proceeds to the bitmap lookup.
- R3: The first read is the 16-bit word at `tr_base+102`, which gives the I/O base. The bitmap offset is I/O base − 32 + (vector >> 3), computed as a 32-bit unsigned value that wraps. If the offset is greater than `tr_limit`, the block reports fault after exactly one read. An offset equal to the limit is allowed.
- R4: The second read is at `tr_base+offset`, and only `rd_data[7:0]` is used. If bit (vector & 7) of that byte is set, the block follows the rule of R1 after exactly two reads.
- R5: If that bit is clear, the block reads the new IP from the word at vector×4 and then the new CS from vector×4+2. It reports them on `new_ip`/`new_cs` with result code 2'b01.
- R6: A redirection makes exactly three 16-bit pushes, in this order: the flags image, the old CS, the old IP.
- R7: The pushed flags image equals `flags_in` when IOPL is 3. Otherwise bits 13:12 are forced to 2'b11 and bit 9 (IF) is replaced by `vif_in`.
- R8: With a redirected result, `clr_tf` and `clr_rf` are high. `clr_if` is high when IOPL is 3, and `clr_vif` is high otherwise. All four are low with any other result.
- R9: `done` is a one-cycle pulse that carries `result`, and `result` is 2'b00 outside that pulse. `busy` is high from the cycle after start until `done`. A start pulse while busy has no effect.
- R10: A request (`rd_req` or `push_req`) holds its address or data stable until it is acknowledged. Read and push requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin evaluation of one interrupt |
| vector | input | 8 | Interrupt vector number |
| ext_en | input | 1 | Virtual-mode extensions enable |
| tr_base | input | AW | Task-state segment linear base |
| tr_limit | input | AW | Task-state segment byte limit |
| flags_in | input | 16 | Current low flags word (TF bit 8, IF bit 9, IOPL bits 13:12) |
| vif_in | input | 1 | Current virtual interrupt flag |
| ip_in | input | 16 | Current instruction pointer |
| cs_in | input | 16 | Current code segment selector |
| busy | output | 1 | Sequence in progress |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_ack | input | 1 | Memory read acknowledge, data valid |
| rd_data | input | 16 | Memory read data |
| push_req | output | 1 | Stack push request |
| push_data | output | 16 | Word to push |
| push_ack | input | 1 | Stack push acknowledge |
| done | output | 1 | Result strobe |
| result | output | 2 | 01 redirected, 10 not redirected, 11 fault |
| new_ip | output | 16 | IP from the vector table |
| new_cs | output | 16 | CS from the vector table |
| clr_tf | output | 1 | Clear trap flag |
| clr_rf | output | 1 | Clear resume flag |
| clr_if | output | 1 | Clear interrupt flag |
| clr_vif | output | 1 | Clear virtual interrupt flag |

## Verification
A wrong offset register or a wrong bit select shows up at the ports as soon as the second read is requested: either the bitmap address is wrong, or the result is wrong within the next few cycles. A wrong captured flags, CS or IP value shows up in the pushed words before `done`. A state sequence that goes astray shows up as a missing or extra read or push, or as a result code that does not match the one computed from the vector, IOPL and the bitmap pattern. The bench sweeps all 256 vectors at every IOPL level, and adds boundary cases for the limit and the offset.

// File: rtl/vint_redirect.sv
module vint_redirect #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    vector,
  input  logic          ext_en,
  input  logic [AW-1:0] tr_base,
  input  logic [AW-1:0] tr_limit,
  input  logic [15:0]   flags_in,
  input  logic          vif_in,
  input  logic [15:0]   ip_in,
  input  logic [15:0]   cs_in,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  output logic          push_req,
  output logic [15:0]   push_data,
  input  logic          push_ack,
  output logic          done,
  output logic [1:0]    result,
  output logic [15:0]   new_ip,
  output logic [15:0]   new_cs,
  output logic          clr_tf,
  output logic          clr_rf,
  output logic          clr_if,
  output logic          clr_vif
);
  localparam logic [1:0] RES_REDIR = 2'b01;
  localparam logic [1:0] RES_PASS  = 2'b10;
  localparam logic [1:0] RES_FAULT = 2'b11;
  localparam logic [AW-1:0] IOB_OFS   = AW'(102);
  localparam logic [AW-1:0] MIN_LIMIT = AW'(103);

  typedef enum logic [3:0] {
    S_IDLE, S_IOB, S_BMP, S_VIP, S_VCS, S_PFL, S_PCS, S_PIP, S_DONE
  } state_t;

  state_t        state;
  logic [7:0]    vec_q;
  logic [AW-1:0] base_q, lim_q, off_q;
  logic [15:0]   fl_q, ip_q, cs_q, nip_q, ncs_q;
  logic          vif_q;
  logic [1:0]    res_q;

  logic          lt3_q, lt3_in;
  logic [AW-1:0] off_calc;
  logic          bmp_bit;
  logic [15:0]   fl_img;

  assign lt3_q    = fl_q[13:12] != 2'b11;
  assign lt3_in   = flags_in[13:12] != 2'b11;
  assign off_calc = AW'(rd_data) + AW'(vec_q[7:3]) - AW'(32);
  assign bmp_bit  = rd_data[vec_q[2:0]];
  assign fl_img   = lt3_q ? {fl_q[15:14], 2'b11, fl_q[11:10], vif_q, fl_q[8:0]} : fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vec_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
      off_q  <= '0;
      fl_q   <= '0;
      vif_q  <= 1'b0;
      ip_q   <= '0;
      cs_q   <= '0;
      nip_q  <= '0;
      ncs_q  <= '0;
      res_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          vec_q  <= vector;
          base_q <= tr_base;
          lim_q  <= tr_limit;
          fl_q   <= flags_in;
          vif_q  <= vif_in;
          ip_q   <= ip_in;
          cs_q   <= cs_in;
          if (!ext_en) begin
            res_q <= lt3_in ? RES_FAULT : RES_PASS;
            state <= S_DONE;
          end else if (tr_limit < MIN_LIMIT) begin
            res_q <= RES_FAULT;
            state <= S_DONE;
          end else begin
            state <= S_IOB;
          end
        end
        S_IOB: if (rd_ack) begin
          if (off_calc > lim_q) begin
            res_q <= RES_FAULT;
            state <= S_DONE;
          end else begin
            off_q <= off_calc;
            state <= S_BMP;
          end
        end
        S_BMP: if (rd_ack) begin
          if (bmp_bit) begin
            res_q <= lt3_q ? RES_FAULT : RES_PASS;
            state <= S_DONE;
          end else begin
            state <= S_VIP;
          end
        end
        S_VIP: if (rd_ack) begin
          nip_q <= rd_data;
          state <= S_VCS;
        end
        S_VCS: if (rd_ack) begin
          ncs_q <= rd_data;
          state <= S_PFL;
        end
        S_PFL: if (push_ack) state <= S_PCS;
        S_PCS: if (push_ack) state <= S_PIP;
        S_PIP: if (push_ack) begin
          res_q <= RES_REDIR;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_addr = '0;
    case (state)
      S_IOB:   rd_addr = base_q + IOB_OFS;
      S_BMP:   rd_addr = base_q + off_q;
      S_VIP:   rd_addr = AW'({vec_q, 2'b00});
      S_VCS:   rd_addr = AW'({vec_q, 2'b10});
      default: rd_addr = '0;
    endcase
  end

  always_comb begin
    push_data = '0;
    case (state)
      S_PFL:   push_data = fl_img;
      S_PCS:   push_data = cs_q;
      S_PIP:   push_data = ip_q;
      default: push_data = '0;
    endcase
  end

  assign rd_req   = state inside {S_IOB, S_BMP, S_VIP, S_VCS};
  assign push_req = state inside {S_PFL, S_PCS, S_PIP};
  assign busy     = state != S_IDLE;
  assign done     = state == S_DONE;
  assign result   = done ? res_q : 2'b00;
  assign new_ip   = nip_q;
  assign new_cs   = ncs_q;

  logic redir_done;
  assign redir_done = done && (res_q == RES_REDIR);
  assign clr_tf  = redir_done;
  assign clr_rf  = redir_done;
  assign clr_if  = redir_done && !lt3_q;
  assign clr_vif = redir_done && lt3_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R10
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ack |=> push_req && $stable(push_data)); // R10
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && push_req)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> result == 2'b00); // R9
  AST_CLR_ONLY_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tf || clr_rf || clr_if || clr_vif) |-> done && result == RES_REDIR); // R8
  AST_CLR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_REDIR |-> clr_tf && clr_rf && $onehot({clr_if, clr_vif})); // R8
  AST_NO_REQ_AFTER_SMALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && start && (!ext_en || tr_limit < MIN_LIMIT) |=> done && !rd_req); // R2
  AST_PUSH_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_req) |-> $past(rd_req)); // R6
endmodule

// File: tb/test_vint_redirect.sv
module test_vint_redirect;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] TB_BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0, start = 0, ext_en = 0, vif_in = 0;
  logic [7:0] vector = 0;
  logic [31:0] tr_base = TB_BASE, tr_limit = 0;
  logic [15:0] flags_in = 0, ip_in = 0, cs_in = 0;
  logic busy, rd_req, push_req, done, clr_tf, clr_rf, clr_if, clr_vif;
  logic [31:0] rd_addr;
  logic rd_ack = 0, push_ack = 0;
  logic [15:0] rd_data = 0, push_data, new_ip, new_cs;
  logic [1:0] result;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] iob_val = 0;
  logic [31:0] rd_log [8];
  logic [15:0] push_log [8];
  int rd_n = 0, push_n = 0;

  vint_redirect #(.AW(AW)) i_vint_redirect (
    .clk, .rst_n, .start, .vector, .ext_en, .tr_base, .tr_limit, .flags_in,
    .vif_in, .ip_in, .cs_in, .busy, .rd_req, .rd_addr, .rd_ack, .rd_data,
    .push_req, .push_data, .push_ack, .done, .result, .new_ip, .new_cs,
    .clr_tf, .clr_rf, .clr_if, .clr_vif);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem(input logic [31:0] a);
    if (a == TB_BASE + 32'd102) return iob_val;
    if (a < 32'd1024) return 16'(a * 32'h9E37) ^ 16'h1234;
    return {8'hEE, a[7:0] * 8'd29 ^ 8'h6B};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rd_req && !rd_ack) begin
      if (rd_n < 8) rd_log[rd_n] = rd_addr;
      rd_n++;
      rd_data = mem(rd_addr);
      rd_ack = 1;
    end else rd_ack = 0;
    if (push_req && !push_ack && (cycles % 3 != 0)) begin
      if (push_n < 8) push_log[push_n] = push_data;
      push_n++;
      push_ack = 1;
    end else push_ack = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] v, input logic en, input logic [1:0] iopl,
                     input logic vif, input logic [31:0] lim, input logic [15:0] iob,
                     input logic poke);
    logic [31:0] off;
    logic [15:0] fl, img;
    logic [1:0] exp_res, got_res;
    int exp_rd, exp_push, n;
    logic [15:0] g_ip, g_cs;
    logic g_tf, g_rf, g_if, g_vif;
    fl = 16'h0A55 ^ {8'h0, v};
    fl[8] = 1; fl[13:12] = iopl;
    iob_val = iob;
    @(negedge clk);
    rd_n = 0; push_n = 0;
    vector = v; ext_en = en; vif_in = vif; tr_limit = lim; flags_in = fl;
    ip_in = {v, 8'h3C}; cs_in = {8'h71, ~v};
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    got_res = 0; g_ip = 0; g_cs = 0; g_tf = 0; g_rf = 0; g_if = 0; g_vif = 0;
    while (!done && n < 100) begin
      if (poke && n == 2) begin vector = ~v; start = 1; end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    if (done) begin
      got_res = result; g_ip = new_ip; g_cs = new_cs;
      g_tf = clr_tf; g_rf = clr_rf; g_if = clr_if; g_vif = clr_vif;
    end
    chk("R9 done seen", {31'b0, done}, 32'd1);
    off = {16'b0, iob} - 32'd32 + {27'b0, v[7:3]};
    exp_push = 0;
    if (!en) begin exp_res = (iopl < 3) ? 2'b11 : 2'b10; exp_rd = 0; end
    else if (lim < 32'd103) begin exp_res = 2'b11; exp_rd = 0; end
    else if (off > lim) begin exp_res = 2'b11; exp_rd = 1; end
    else if (mem(TB_BASE + off)[v[2:0]]) begin
      exp_res = (iopl < 3) ? 2'b11 : 2'b10; exp_rd = 2;
    end else begin exp_res = 2'b01; exp_rd = 4; exp_push = 3; end
    chk("R1 R2 R3 R4 result", {30'b0, got_res}, {30'b0, exp_res});
    chk("R1 R2 R3 R4 read count", rd_n, exp_rd);
    chk("R6 push count", push_n, exp_push);
    if (exp_rd >= 1) chk("R3 iobase address", rd_log[0], TB_BASE + 32'd102);
    if (exp_rd >= 2) chk("R4 bitmap address", rd_log[1], TB_BASE + off);
    if (exp_res == 2'b01) begin
      chk("R5 ip address", rd_log[2], {22'b0, v, 2'b00});
      chk("R5 cs address", rd_log[3], {22'b0, v, 2'b10});
      chk("R5 new_ip", {16'b0, g_ip}, {16'b0, mem({22'b0, v, 2'b00})});
      chk("R5 new_cs", {16'b0, g_cs}, {16'b0, mem({22'b0, v, 2'b10})});
      img = fl;
      if (iopl < 3) begin img[13:12] = 2'b11; img[9] = vif; end
      chk("R7 pushed flags", {16'b0, push_log[0]}, {16'b0, img});
      chk("R6 pushed cs", {16'b0, push_log[1]}, {16'b0, 8'h71, ~v});
      chk("R6 pushed ip", {16'b0, push_log[2]}, {16'b0, v, 8'h3C});
      chk("R8 clears", {28'b0, g_tf, g_rf, g_if, g_vif},
          {28'b0, 1'b1, 1'b1, iopl == 3, iopl != 3});
    end else begin
      chk("R8 no clears", {28'b0, g_tf, g_rf, g_if, g_vif}, 32'd0);
    end
    @(negedge clk);
    chk("R9 idle after done", {30'b0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset state", {28'b0, busy, done, rd_req, push_req}, 32'd0);
    chk("R9 reset result", {30'b0, result}, 32'd0);
    rst_n = 1;
    for (int ip = 0; ip < 4; ip++)
      for (int v = 0; v < 256; v++)
        run(8'(v), 1'b1, 2'(ip), v[0], 32'h2000, 16'd200, v % 37 == 5);
    for (int ip = 0; ip < 4; ip++)
      for (int v = 0; v < 256; v += 51)
        run(8'(v), 1'b0, 2'(ip), 1'b1, 32'h2000, 16'd200, 1'b0);
    for (int ip = 2; ip < 4; ip++) begin
      run(8'h21, 1'b1, 2'(ip), 1'b0, 32'd102, 16'd100, 1'b0);
      run(8'h21, 1'b1, 2'(ip), 1'b0, 32'd103, 16'd100, 1'b0);
      run(8'h40, 1'b1, 2'(ip), 1'b0, 32'd4000, 16'd4024, 1'b0);
      run(8'h40, 1'b1, 2'(ip), 1'b0, 32'd3999, 16'd4024, 1'b0);
      run(8'h08, 1'b1, 2'(ip), 1'b1, 32'h2000, 16'd0, 1'b0);
      run(8'h10, 1'b1, 2'(ip), 1'b1, 32'h2000, 16'd30, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule